// File: doc/BRIEF.md
# Multi-Size Subword Parallel Adder

This block is a SIMD arithmetic unit for a 48-bit datapath. The datapath is split into independent signed lanes whose width suits multimedia samples: 8, 10, 12 or 16 bits. The lane width is chosen with each operation. One operation applies the same function to every lane at once: lane-wise addition, lane-wise subtraction, or lane-wise absolute value.

Carries never cross from one lane into the next. Lanes of 10 and 12 bits do not start on 8-bit boundaries, so the points where the carry chain is broken depend on the selected lane width. Each lane reports its own signed-overflow flag.

Results and flags are registered once. A valid strobe travels alongside the data with one clock of latency.

Top module: `swp_adder`

## Requirements
- R1: While synchronous active-high `rst` is sampled high, the next clock edge clears `result`, `ovf` and `out_valid` to zero.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. When `in_valid` is low, `result` and `ovf` keep their previous values.
- R3: The size code sets the lane width: 00 gives six lanes of 8 bits, 01 gives four lanes of 10 bits, 10 gives four lanes of 12 bits, and 11 gives three lanes of 16 bits. Lane k occupies bits starting at k times the width. Opcode 00 gives, in each lane, a+b modulo 2^width.
- R4: A carry out of any lane's top bit never reaches the next lane. For example, in 10-bit mode, 0x3FF+1 in lane 0 gives 0 in lane 0 and leaves lane 1 unaffected.
- R5: Opcode 01 gives, in each lane, a minus b modulo 2^width.
- R6: Opcode 10 gives the absolute value of each two's-complement lane of `opa`. `opb` has no effect on this operation.
- R7: The absolute value of the most negative lane value wraps to that same value and sets the lane's overflow flag.
- R8: `ovf` bit k is set exactly when lane k's signed add or subtract result falls outside the lane's signed range. Bit 0 belongs to the lowest lane.
- R9: Flags for lane positions beyond the lane count are zero. In 10-bit mode, result bits 47:40 are zero.
- R10: Opcode 11 is reserved. It produces an all-zero result and all-zero flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| size_sel | input | 2 | Lane width code |
| op_sel | input | 2 | Operation code |
| opa | input | 48 | First operand |
| opb | input | 48 | Second operand |
| out_valid | output | 1 | Result strobe |
| result | output | 48 | Packed lane results |
| ovf | output | 6 | Per-lane signed overflow flags |

## Verification
Every result, flag and valid strobe is due on the first rising edge after the operands are presented. No register stands between the inputs and that edge other than the output register. The bench drives each operation on a falling edge and samples on the next falling edge, which is half a cycle after the output register has loaded. For the hold case, the bench drops `in_valid` and samples again one and two falling edges later, confirming that `out_valid` is low and the previous outputs are unchanged.

// File: rtl/swp_adder.sv
module swp_adder #(
  parameter int DW = 48,
  parameter int NL = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    size_sel,
  input  logic [1:0]    op_sel,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic          out_valid,
  output logic [DW-1:0] result,
  output logic [NL-1:0] ovf
);

  logic [DW-1:0] sum_n;
  logic [NL-1:0] ovf_n;

  always_comb begin
    int w, nl, pos, lane;
    logic c, x, y, neg, co;
    case (size_sel)
      2'b00:   begin w = 8;  nl = DW / 8;  end
      2'b01:   begin w = 10; nl = DW / 10; end
      2'b10:   begin w = 12; nl = DW / 12; end
      default: begin w = 16; nl = DW / 16; end
    endcase
    sum_n = '0;
    ovf_n = '0;
    c = 1'b0;
    neg = 1'b0;
    pos = 0;
    lane = 0;
    for (int i = 0; i < DW; i++) begin
      if (lane < nl && op_sel != 2'b11) begin
        if (pos == 0) begin
          neg = opa[i + w - 1];
          case (op_sel)
            2'b01:   c = 1'b1;
            2'b10:   c = neg;
            default: c = 1'b0;
          endcase
        end
        case (op_sel)
          2'b00:   begin x = opa[i]; y = opb[i]; end
          2'b01:   begin x = opa[i]; y = ~opb[i]; end
          default: begin x = neg ? 1'b0 : opa[i]; y = neg ? ~opa[i] : 1'b0; end
        endcase
        sum_n[i] = x ^ y ^ c;
        co = (x & y) | (x & c) | (y & c);
        if (pos == w - 1) begin
          ovf_n[lane] = c ^ co;
          lane = lane + 1;
          pos = 0;
        end else begin
          pos = pos + 1;
        end
        c = co;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= sum_n;
        ovf    <= ovf_n;
      end
    end
  end

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(ovf)));
  p_unused10_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_sel == 2'b01) |=> (result[DW-1:40] == '0 && ovf[NL-1:4] == '0));
  p_flags16_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size_sel == 2'b11) |=> (ovf[NL-1:3] == '0));
  p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b11) |=> (result == '0 && ovf == '0));
  p_sub_self_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 2'b01 && opa == opb) |=> (result == '0 && ovf == '0));

endmodule

// File: tb/swp_adder_test.sv
module swp_adder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] size_sel = '0;
  logic [1:0] op_sel = '0;
  logic [47:0] opa = '0;
  logic [47:0] opb = '0;
  logic out_valid;
  logic [47:0] result;
  logic [5:0] ovf;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  swp_adder uut (.clk(clk), .rst(rst), .in_valid(in_valid), .size_sel(size_sel),
    .op_sel(op_sel), .opa(opa), .opb(opb), .out_valid(out_valid),
    .result(result), .ovf(ovf));

  task automatic model(input logic [47:0] a, input logic [47:0] b, input logic [1:0] sz,
                       input logic [1:0] op, output logic [47:0] r, output logic [5:0] f);
    int w, n;
    longint m, ua, ub, sa, sb, s;
    r = '0; f = '0;
    w = (sz == 0) ? 8 : (sz == 1) ? 10 : (sz == 2) ? 12 : 16;
    n = 48 / w;
    if (op == 2'b11) return;
    m = (64'sd1 << w);
    for (int k = 0; k < n; k++) begin
      ua = longint'((a >> (k * w))) & (m - 1);
      ub = longint'((b >> (k * w))) & (m - 1);
      sa = (ua >= m / 2) ? ua - m : ua;
      sb = (ub >= m / 2) ? ub - m : ub;
      if (op == 0) s = sa + sb;
      else if (op == 1) s = sa - sb;
      else s = (sa < 0) ? -sa : sa;
      if (s >= m / 2 || s < -(m / 2)) f[k] = 1'b1;
      s = s & (m - 1);
      r = r | (48'(s) << (k * w));
    end
  endtask

  task automatic chk(input string tag, input logic [47:0] er, input logic [5:0] ef, input logic ev);
    checks++;
    if (result !== er || ovf !== ef || out_valid !== ev) begin
      failures++;
      $display("FAIL %s: result=%h ovf=%b valid=%b expected result=%h ovf=%b valid=%b",
               tag, result, ovf, out_valid, er, ef, ev);
    end
  endtask

  task automatic run(input string tag, input logic [1:0] sz, input logic [1:0] op,
                     input logic [47:0] a, input logic [47:0] b);
    logic [47:0] er; logic [5:0] ef;
    model(a, b, sz, op, er, ef);
    @(negedge clk);
    size_sel = sz; op_sel = op; opa = a; opb = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, er, ef, 1'b1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset state", '0, '0, 1'b0);
  endtask

  task automatic t_add;
    for (int s = 0; s < 4; s++) begin
      run("R3 add pattern A", 2'(s), 2'b00, 48'h1234_5678_9ABC, 48'h0FED_CBA9_8765);
      run("R3 add pattern B", 2'(s), 2'b00, 48'hA5A5_5A5A_F00F, 48'h3C3C_C3C3_0FF0);
    end
  endtask

  task automatic t_carry;
    run("R4 carry kill 8", 2'b00, 2'b00, 48'h0000_0000_00FF, 48'h0000_0000_0001);
    run("R4 carry kill 10", 2'b01, 2'b00, 48'h0000_0000_03FF, 48'h0000_0000_0001);
    run("R4 carry kill 12", 2'b10, 2'b00, 48'hFFF_FFF_FFF_FFF, 48'h001_001_001_001);
    run("R4 carry kill 16", 2'b11, 2'b00, 48'hFFFF_FFFF_FFFF, 48'h0001_0001_0001);
  endtask

  task automatic t_sub;
    for (int s = 0; s < 4; s++) begin
      run("R5 subtract", 2'(s), 2'b01, 48'h1111_2222_3333, 48'h4444_0123_FFFF);
      run("R5 subtract equal", 2'(s), 2'b01, 48'h7E57_1DEA_C0DE, 48'h7E57_1DEA_C0DE);
    end
  endtask

  task automatic t_abs;
    for (int s = 0; s < 4; s++) begin
      run("R6 abs b=0", 2'(s), 2'b10, 48'h8123_F0E1_7F05, 48'h0);
      run("R6 abs b ignored", 2'(s), 2'b10, 48'h8123_F0E1_7F05, 48'hFFFF_FFFF_FFFF);
    end
  endtask

  task automatic t_abs_min;
    run("R7 abs min 8", 2'b00, 2'b10, 48'h80_01_80_FF_80_7F, 48'h0);
    run("R7 abs min 10", 2'b01, 2'b10, {8'h00, 10'h200, 10'h1FF, 10'h200, 10'h3FF}, 48'h0);
    run("R7 abs min 12", 2'b10, 2'b10, 48'h800_001_800_FFF, 48'h0);
    run("R7 abs min 16", 2'b11, 2'b10, 48'h8000_8000_0001, 48'h0);
  endtask

  task automatic t_ovf;
    run("R8 add overflow 8", 2'b00, 2'b00, 48'h7F_80_7F_80_40_C0, 48'h01_FF_00_80_40_C0);
    run("R8 sub overflow 12", 2'b10, 2'b01, 48'h7FF_800_000_800, 48'hFFF_001_001_000);
    run("R8 add overflow 16", 2'b11, 2'b00, 48'h7FFF_8000_4000, 48'h0001_8000_4000);
  endtask

  task automatic t_unused;
    run("R9 10-bit upper bits", 2'b01, 2'b00, 48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF);
    run("R9 10-bit ovf upper", 2'b01, 2'b00, 48'hFF1FF7FDFF7F, 48'hFF0010040100);
    run("R9 16-bit flags upper", 2'b11, 2'b00, 48'h7FFF_7FFF_7FFF, 48'h7FFF_7FFF_7FFF);
  endtask

  task automatic t_reserved;
    run("R10 reserved op", 2'b00, 2'b11, 48'h7F7F_7F7F_7F7F, 48'h0101_0101_0101);
    run("R10 reserved op 16", 2'b11, 2'b11, 48'hFFFF_0000_8000, 48'h1234_5678_9ABC);
  endtask

  task automatic t_hold;
    logic [47:0] er; logic [5:0] ef;
    model(48'h0102_0304_0506, 48'h1111_1111_1111, 2'b00, 2'b00, er, ef);
    run("R2 valid latency", 2'b00, 2'b00, 48'h0102_0304_0506, 48'h1111_1111_1111);
    opa = 48'hFFFF_FFFF_FFFF; opb = 48'hFFFF_FFFF_FFFF; op_sel = 2'b01;
    @(negedge clk);
    chk("R2 hold with in_valid low", er, ef, 1'b0);
    @(negedge clk);
    chk("R2 hold second cycle", er, ef, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_add();
    t_carry();
    t_sub();
    t_abs();
    t_abs_min();
    t_ovf();
    t_unused();
    t_reserved();
    t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=complete");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule